// File: doc/BRIEF.md
# Pin-Event to Interrupt-Line Router

This block sits in a chip's system-configuration space and steers GPIO pin events onto a fixed set of interrupt lines. Nine ports of sixteen pins each present one event level per pin, 144 inputs in all. There are sixteen interrupt lines, and line `n` can only ever be driven by pin `n` of some port. A 4-bit selector field per line names that port. Sixteen fields means four selector words of four fields each. The line output is a combinational copy of the chosen pin's level.

Software reaches the block through a plain word-addressed register port: a write strobe, a read strobe, a byte address inside a 1 KiB window, and 32-bit data. Two legacy words, a memory-remap word and a peripheral-mode word, are decoded but hold nothing: writes to them are dropped and they read as zero. A compensation-control word is plain 32-bit storage. Every other offset reads as zero and ignores writes.

Top module: `evt_line_router`

## Requirements
- R1: After reset every register reads 0x00000000, so every line n follows pin n of port 0.
- R2: Line n equals event input `16*f + n`, where f is the 4-bit field in selector word n/4 (byte offsets 0x08, 0x0C, 0x10, 0x14 for words 0..3) at bits `4*(n%4)+3 : 4*(n%4)`.
- R3: Event inputs of ports that a line's field does not name have no effect on that line.
- R4: A field value from 9 to 15 names no port, and that line is held at 0.
- R5: A write to a selector word stores only write-data bits 15:0. Bits 31:16 of a selector word always read as 0.
- R6: Writes to the remap word (0x00) and the mode word (0x04) are dropped. Both always read 0 and leave every line's source unchanged.
- R7: The compensation word (0x20) stores all 32 bits written and reads them back unchanged.
- R8: A read at any other offset in the window returns 0, and a write there changes no register.
- R9: Address bits 1:0 are ignored. Read data is registered: it appears on `cfg_rdata` the cycle after `cfg_re` and holds until the next read. A read in the same cycle as a write returns the old value.
- R10: A selector write moves the line to its new source from the clock edge that accepts the write. After that the line follows pin changes with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 10 | Byte address inside the 1 KiB window |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| pin_evt | input | 144 | Event levels; bit 16*p+k is pin k of port p |
| irq_line | output | 16 | Routed interrupt lines |

## Verification
The bench drives every input on the falling edge. A read result is due one rising edge after the strobe, so the bench samples `cfg_rdata` on the next falling edge. A line output has no register between pin and line: the bench samples it 1 ns after changing `pin_evt`, in the same half cycle. After a selector write it checks the line at the falling edge that follows the accepting rising edge. The expected line value comes from a shadow copy of the selector words, with the port index, pin and field extracted by arithmetic.

// File: rtl/evtsel_pkg.sv
package evtsel_pkg;

  // Word indices (byte offset / 4) of the decoded registers.
  localparam int unsigned REMAP_WIDX    = 0;
  localparam int unsigned MODE_WIDX     = 1;
  localparam int unsigned SEL_BASE_WIDX = 2;
  localparam int unsigned COMP_WIDX     = 8;

  typedef enum logic [2:0] {
    RK_NONE  = 3'd0,
    RK_REMAP = 3'd1,
    RK_MODE  = 3'd2,
    RK_SEL   = 3'd3,
    RK_COMP  = 3'd4
  } reg_kind_e;

endpackage

// File: rtl/evtsel_addr_dec.sv
module evtsel_addr_dec
  import evtsel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_SEL = 4,
  localparam int unsigned WORD_W = ADDR_W - 2,
  localparam int unsigned SIDX_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [SIDX_W-1:0] sel_idx
);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] sel_off;
  logic              unused_bits;

  assign word        = addr[ADDR_W-1:2];
  assign sel_off     = word - WORD_W'(SEL_BASE_WIDX);
  assign sel_idx     = sel_off[SIDX_W-1:0];
  assign unused_bits = ^{addr[1:0], sel_off};

  always_comb begin
    kind = RK_NONE;
    if (word == WORD_W'(REMAP_WIDX)) begin
      kind = RK_REMAP;
    end else if (word == WORD_W'(MODE_WIDX)) begin
      kind = RK_MODE;
    end else if (word >= WORD_W'(SEL_BASE_WIDX) &&
                 word <  WORD_W'(SEL_BASE_WIDX + NUM_SEL)) begin
      kind = RK_SEL;
    end else if (word == WORD_W'(COMP_WIDX)) begin
      kind = RK_COMP;
    end
  end

endmodule

// File: rtl/evtsel_regbank.sv
module evtsel_regbank
  import evtsel_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_SEL     = 4,
  parameter int unsigned SEL_STORE_W = 16,
  localparam int unsigned SIDX_W     = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic                           re,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_SEL*SEL_STORE_W-1:0] sel_flat
);

  reg_kind_e         kind;
  logic [SIDX_W-1:0] sidx;
  logic [SEL_STORE_W-1:0] sel_q [NUM_SEL];
  logic [DATA_W-1:0] comp_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  evtsel_addr_dec #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)) u_dec (
    .addr    (addr),
    .kind    (kind),
    .sel_idx (sidx)
  );

  // Selector words: only the low SEL_STORE_W bits are kept.
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= '0;
      end else if (we && kind == RK_SEL && sidx == SIDX_W'(g)) begin
        sel_q[g] <= wdata[SEL_STORE_W-1:0];
      end
    end
    assign sel_flat[g*SEL_STORE_W +: SEL_STORE_W] = sel_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
    end else if (we && kind == RK_COMP) begin
      comp_q <= wdata;
    end
  end

  // Remap and mode words hold no storage: they read as zero.
  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_SEL:  rd_mux = {{(DATA_W-SEL_STORE_W){1'b0}}, sel_q[sidx]};
      RK_COMP: rd_mux = comp_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;

  p_sel_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (re && kind == RK_SEL) |=> (rdata[DATA_W-1:SEL_STORE_W] == '0));

  p_dropped_regs_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (kind == RK_REMAP || kind == RK_MODE)) |=> (rdata == '0));

  p_comp_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && kind == RK_COMP) ##1 (re && !we && kind == RK_COMP)
      |=> (rdata == $past(wdata, 2)));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (re && kind == RK_NONE) |=> (rdata == '0));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/evtsel_line_mux.sv
module evtsel_line_mux #(
  parameter int unsigned NUM_PORTS = 9,
  parameter int unsigned SEL_W     = 4
) (
  input  logic [NUM_PORTS-1:0] port_pins,
  input  logic [SEL_W-1:0]     field,
  output logic                 line
);

  logic [NUM_PORTS-1:0] hit;

  // One-hot match: a field value naming no port leaves every hit low.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign hit[p] = (field == SEL_W'(p)) & port_pins[p];
  end

  assign line = |hit;

endmodule

// File: rtl/evt_line_router.sv
module evt_line_router #(
  parameter int unsigned NUM_PORTS = 9,
  parameter int unsigned PINS      = 16,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned FIELDS_PER_WORD = 4,
  localparam int unsigned NUM_SEL     = PINS / FIELDS_PER_WORD,
  localparam int unsigned SEL_STORE_W = FIELDS_PER_WORD * SEL_W,
  localparam int unsigned NUM_EVT     = NUM_PORTS * PINS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [NUM_EVT-1:0] pin_evt,
  output logic [PINS-1:0]    irq_line
);

  logic [NUM_SEL*SEL_STORE_W-1:0] sel_flat;

  evtsel_regbank #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_SEL     (NUM_SEL),
    .SEL_STORE_W (SEL_STORE_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .re       (cfg_re),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .sel_flat (sel_flat)
  );

  // Selector fields are stored in line order, SEL_W bits each, so field n
  // sits in word n/4 at bit 4*(n%4) of that word.
  for (genvar n = 0; n < PINS; n++) begin : g_line
    logic [NUM_PORTS-1:0] column;
    logic [SEL_W-1:0]     fld;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign column[p] = pin_evt[p*PINS + n];
    end

    assign fld = sel_flat[n*SEL_W +: SEL_W];

    evtsel_line_mux #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_mux (
      .port_pins (column),
      .field     (fld),
      .line      (irq_line[n])
    );

    p_no_port_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fld >= SEL_W'(NUM_PORTS)) |-> !irq_line[n]);

    p_line_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fld < SEL_W'(NUM_PORTS)) |-> (irq_line[n] == pin_evt[32'(fld)*PINS + n]));
  end

endmodule

// File: tb/sim_evt_line_router.sv
`timescale 1ns/1ps
module sim_evt_line_router;

  localparam int NP = 9;
  localparam int NPIN = 16;
  localparam int NEVT = NP * NPIN;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic         cfg_re = 1'b0;
  logic [9:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic [NEVT-1:0] pin_evt = '0;
  logic [15:0]  irq_line;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] shadow [4];
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] got32;

  always #5 clk = ~clk;

  evt_line_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pin_evt(pin_evt), .irq_line(irq_line)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  function automatic logic [15:0] model_lines();
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      int f = (shadow[n/4] >> (4*(n%4))) & 15;
      r[n] = (f < NP) ? pin_evt[f*NPIN + n] : 1'b0;
    end
    return r;
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic wr_sel(input int w, input logic [31:0] d);
    wr(10'h008 + 10'(4*w), d);
    shadow[w] = d[15:0];
  endtask

  task automatic chk_lines(input string req);
    #1;
    check(req, {16'h0, irq_line}, {16'h0, model_lines()});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int w = 0; w < 4; w++) shadow[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and port-0 routing
    for (int a = 0; a < 9; a++) begin
      rd(10'(4*a), got32);
      check("R1 reset read", got32, 32'h0);
    end
    pin_evt = '1;
    #1 check("R1 all lines from port0", {16'h0, irq_line}, 32'h0000_ffff);
    pin_evt = '1; pin_evt[15:0] = '0;
    #1 check("R1 other ports ignored", {16'h0, irq_line}, 32'h0);

    // R2/R3/R4: sweep every field value, port and pin
    for (int f = 0; f < 16; f++) begin
      for (int w = 0; w < 4; w++) wr_sel(w, 32'hA5C3_0000 | (32'(f) * 32'h1111));
      for (int p = 0; p < NP; p++) begin
        for (int k = 0; k < NPIN; k++) begin
          @(negedge clk);
          pin_evt = '0;
          pin_evt[p*NPIN + k] = 1'b1;
          chk_lines((f >= NP) ? "R4 sweep" : (p == f ? "R2 sweep" : "R3 sweep"));
        end
      end
      @(negedge clk);
      pin_evt = '1;
      chk_lines(f >= NP ? "R4 all ones" : "R2 all ones");
    end

    // R5: upper half not stored
    for (int w = 0; w < 4; w++) begin
      wr_sel(w, 32'hFFFF_0000 | 32'(16'h1357 + 16'(w)));
      rd(10'h008 + 10'(4*w), got32);
      check("R5 selector readback", got32, {16'h0, shadow[w]});
    end

    // R2 mixed selectors and random pins, R10 same-edge switching
    for (int i = 0; i < 300; i++) begin
      rng = next_rng(rng);
      wr_sel(i % 4, rng);
      chk_lines("R10 after selector write");
      for (int j = 0; j < 5; j++) begin
        rng = next_rng(rng);
        if (j < 4) pin_evt[j*32 +: 32] = rng;
        else pin_evt[143:128] = rng[15:0];
      end
      chk_lines("R2 random");
    end

    // R6: dropped registers
    wr(10'h000, 32'hFFFF_FFFF);
    wr(10'h004, 32'hDEAD_BEEF);
    rd(10'h000, got32); check("R6 remap reads zero", got32, 32'h0);
    rd(10'h004, got32); check("R6 mode reads zero", got32, 32'h0);
    chk_lines("R6 lines unchanged");
    for (int w = 0; w < 4; w++) begin
      rd(10'h008 + 10'(4*w), got32);
      check("R6 selectors unchanged", got32, {16'h0, shadow[w]});
    end

    // R7: compensation word
    wr(10'h020, 32'h8765_4321);
    rd(10'h020, got32); check("R7 comp readback", got32, 32'h8765_4321);
    wr(10'h020, 32'hFFFF_FFFF);
    rd(10'h020, got32); check("R7 comp all ones", got32, 32'hFFFF_FFFF);

    // R8: unmapped offsets
    wr(10'h018, 32'h1111_1111);
    wr(10'h01C, 32'h2222_2222);
    wr(10'h3FC, 32'h3333_3333);
    wr(10'h024, 32'h4444_4444);
    rd(10'h018, got32); check("R8 unmapped 0x18", got32, 32'h0);
    rd(10'h3FC, got32); check("R8 unmapped 0x3FC", got32, 32'h0);
    rd(10'h024, got32); check("R8 unmapped 0x24", got32, 32'h0);
    rd(10'h020, got32); check("R8 comp untouched", got32, 32'hFFFF_FFFF);
    for (int w = 0; w < 4; w++) begin
      rd(10'h008 + 10'(4*w), got32);
      check("R8 selectors untouched", got32, {16'h0, shadow[w]});
    end

    // R9: low address bits ignored, registered read, hold, read-during-write
    wr(10'h00B, 32'h0000_4321);
    shadow[0] = 16'h4321;
    rd(10'h009, got32); check("R9 low bits ignored", got32, 32'h0000_4321);
    repeat (3) @(negedge clk);
    check("R9 rdata holds", cfg_rdata, 32'h0000_4321);
    @(negedge clk);
    cfg_we = 1'b1; cfg_re = 1'b1; cfg_addr = 10'h020; cfg_wdata = 32'h0BAD_F00D;
    @(negedge clk);
    cfg_we = 1'b0; cfg_re = 1'b0;
    check("R9 read during write old", cfg_rdata, 32'hFFFF_FFFF);
    rd(10'h020, got32); check("R9 then new value", got32, 32'h0BAD_F00D);
    chk_lines("R2 final");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule